// File: doc/BRIEF.md
# PLL Mode and Lock Sequencer

This block stands in for the control and status side of a digital PLL. Software writes a mode word to ask for either bypass operation or locked operation, and writes a select word that carries an 11-bit multiplier, a 7-bit divider code and a bypass-clock select flag. The block tracks the resulting transitions and reports a bypass flag and a lock flag in a small status word. Each flag rises only after a delay that depends on the mode. Lock is not produced by an analog loop. A settle counter models it, and a write to the select word during the settle window starts that count again.

Beside the status, the block gives the output frequency in Hz that the current settings would produce. It picks one of four reference frequencies with a two-bit input, divides that reference by the divider (the field plus one) using integer division, and then multiplies by the multiplier. When the bypass-clock select flag is set, or when the product does not fit in 32 bits, the result is marked invalid and reads as zero.

Top module: `pll_mode_seq`

## Requirements
- R1: After synchronous reset the status word reads 0x100 (bypass set, lock clear), the select fields are zero, `freq_hz` is 0 and `freq_ok` is 1.
- R2: A mode write (`wr_sel`=0) of exactly 0x00000004, accepted while locking or locked, starts the bypass entry. Bypass status (bit 8) rises, and lock status (bit 0) clears, on the second rising edge counting the one that accepts the write. Until that edge bypass stays 0 and lock keeps its previous value.
- R3: A mode write of exactly 0x00000007, accepted while in bypass or while entering bypass, clears both status bits after the accepting edge. Lock status then rises on the LOCK_CYCLES-th rising edge (default 64), counting the accepting edge.
- R4: A select write (`wr_sel`=1) accepted while locking reloads the settle count, so lock rises on the LOCK_CYCLES-th edge counting the select write's edge.
- R5: A mode write of any other value leaves the status unchanged. So does 0x4 while in bypass or already entering bypass, and so does 0x7 while locking or locked.
- R6: `pll_status` carries bypass in bit 8 and lock in bit 0. Bits 7:1 read 0.
- R7: In a select write the multiplier is taken from bits 18:8, the divider from bits 6:0 plus one, and the bypass-clock select from bit 23. All other bits have no effect on the result.
- R8: `freq_hz` equals multiplier × floor(reference / divider). It is updated on the rising edge after a select write, or after a change of `ref_sel`.
- R9: `ref_sel` chooses the reference as follows: 0 gives 19,200,000 Hz, 1 gives 24,000,000 Hz, 2 gives 25,000,000 Hz and 3 gives 26,000,000 Hz.
- R10: While the bypass-clock select bit is set, `freq_ok` is 0 and `freq_hz` is 0 from the next edge on.
- R11: When the product reaches 2^32 or more, `freq_ok` is 0 and `freq_hz` is 0.
- R12: Bypass and lock status are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_sel | input | 1 | Target: 0 = mode word, 1 = select word |
| wr_data | input | 32 | Write data |
| ref_sel | input | 2 | Reference frequency choice |
| pll_status | output | 9 | Bit 8 bypass, bit 0 locked |
| freq_hz | output | 32 | Computed output frequency in Hz |
| freq_ok | output | 1 | Frequency result valid |

## Verification
The case that is hardest to reach from the ports is a select write that lands inside the lock settle window, together with a lock request that has to be ignored during the same window. The stimulus issues a lock request, repeats it a few cycles later, and then writes the select word part way through the count. It then checks that lock is still low one edge before the reloaded deadline and high on that edge. A second difficult case is the overflow boundary of the product. Multipliers of 165 and 166 with the 26 MHz reference and a divider of one sit on either side of 2^32. A behavioural model, compared on every clock, covers the orderings between these directed points, including a bypass request followed at once by a lock request.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int MULT_W   = 11;
  localparam int DIV_W    = 7;
  localparam int MULT_LSB = 8;
  localparam int DIV_LSB  = 0;
  localparam int BSEL_BIT = 23;
  localparam int REF_W    = 25;
  localparam int FREQ_W   = 32;
  localparam int WORD_W   = 32;

  localparam logic [WORD_W-1:0] MODE_BYPASS = 32'h0000_0004;
  localparam logic [WORD_W-1:0] MODE_LOCK   = 32'h0000_0007;

  typedef enum logic [1:0] {
    ST_BYP     = 2'd0,
    ST_ENTER   = 2'd1,
    ST_LOCKING = 2'd2,
    ST_LOCKED  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic              bsel;
    logic [MULT_W-1:0] mult;
    logic [DIV_W-1:0]  divm1;
  } sel_fields_t;

  function automatic logic [REF_W-1:0] ref_hz_f(input logic [1:0] s);
    case (s)
      2'd0:    ref_hz_f = REF_W'(19_200_000);
      2'd1:    ref_hz_f = REF_W'(24_000_000);
      2'd2:    ref_hz_f = REF_W'(25_000_000);
      default: ref_hz_f = REF_W'(26_000_000);
    endcase
  endfunction

endpackage

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 64,
  parameter int BYP_SETTLE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [WORD_W-1:0] mode_d,
  input  logic              sel_we,
  output logic              byp_q,
  output logic              lck_q
);

  localparam int MAXC  = (LOCK_CYCLES > BYP_SETTLE) ? LOCK_CYCLES : BYP_SETTLE;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             req_byp, req_lock, take_byp, take_lock;

  always_comb begin
    req_byp   = mode_we && (mode_d == MODE_BYPASS);
    req_lock  = mode_we && (mode_d == MODE_LOCK);
    take_byp  = req_byp && (st == ST_LOCKING || st == ST_LOCKED);
    take_lock = req_lock && (st == ST_BYP || st == ST_ENTER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_BYP;
      cnt   <= '0;
      byp_q <= 1'b1;
      lck_q <= 1'b0;
    end else if (take_byp) begin
      st  <= ST_ENTER;
      cnt <= CNT_W'(BYP_SETTLE - 1);
    end else if (take_lock) begin
      st    <= ST_LOCKING;
      cnt   <= CNT_W'(LOCK_CYCLES - 1);
      byp_q <= 1'b0;
      lck_q <= 1'b0;
    end else begin
      case (st)
        ST_ENTER: begin
          if (cnt == CNT_W'(1)) begin
            st    <= ST_BYP;
            cnt   <= '0;
            byp_q <= 1'b1;
            lck_q <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_LOCKING: begin
          if (sel_we) begin
            cnt <= CNT_W'(LOCK_CYCLES - 1);
          end else if (cnt == CNT_W'(1)) begin
            st    <= ST_LOCKED;
            cnt   <= '0;
            lck_q <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // R12: the two status flags are exclusive
  p_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(byp_q && lck_q));

  // R2: the final settle step of bypass entry raises bypass and drops lock
  p_enter_done_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ENTER && cnt == CNT_W'(1) && !req_lock) |=> (byp_q && !lck_q));

  // R3: an accepted lock request clears both flags
  p_lock_start_r3: assert property (@(posedge clk) disable iff (rst)
    take_lock |=> (!byp_q && !lck_q));

  // R4: a select write during settle keeps lock low for at least one more edge
  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOCKING && sel_we && !mode_we) |=> !lck_q);

  // R5: an unknown mode value while locked changes nothing
  p_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_we && !req_byp && !req_lock && st == ST_LOCKED) |=>
      ($stable(byp_q) && $stable(lck_q)));

  // R3: a counting state never holds an empty counter
  p_cnt_live_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOCKING || st == ST_ENTER) |-> (cnt != '0));

endmodule

// File: rtl/pllseq_selreg.sv
module pllseq_selreg
  import pllseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  sel_fields_t d,
  output sel_fields_t q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/pllseq_freq.sv
module pllseq_freq
  import pllseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  sel_fields_t       f,
  input  logic [1:0]        ref_sel,
  output logic [FREQ_W-1:0] freq_q,
  output logic              ok_q
);

  localparam int DFULL_W = DIV_W + 1;
  localparam int PROD_W  = MULT_W + REF_W;

  logic [REF_W-1:0]   ref_w, quot;
  logic [DFULL_W-1:0] div_w;
  logic [PROD_W-1:0]  prod;
  logic               fits;

  always_comb begin
    ref_w = ref_hz_f(ref_sel);
    div_w = {1'b0, f.divm1} + DFULL_W'(1);
    quot  = ref_w / REF_W'(div_w);
    prod  = PROD_W'(f.mult) * PROD_W'(quot);
    fits  = (prod[PROD_W-1:FREQ_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
      ok_q   <= 1'b1;
    end else if (!f.bsel && fits) begin
      freq_q <= prod[FREQ_W-1:0];
      ok_q   <= 1'b1;
    end else begin
      freq_q <= '0;
      ok_q   <= 1'b0;
    end
  end

  // R10: bypass-clock select invalidates the result on the next edge
  p_bsel_r10: assert property (@(posedge clk) disable iff (rst)
    f.bsel |=> !ok_q);

endmodule

// File: rtl/pll_mode_seq.sv
module pll_mode_seq
  import pllseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 64,
  parameter int BYP_SETTLE  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  ref_sel,
  output logic [8:0]  pll_status,
  output logic [31:0] freq_hz,
  output logic        freq_ok
);

  logic        mode_we, sel_we, byp, lck;
  sel_fields_t sel_d, sel_q;

  always_comb begin
    mode_we    = wr_en && !wr_sel;
    sel_we     = wr_en && wr_sel;
    sel_d.bsel  = wr_data[BSEL_BIT];
    sel_d.mult  = wr_data[MULT_LSB +: MULT_W];
    sel_d.divm1 = wr_data[DIV_LSB +: DIV_W];
    pll_status = {byp, 7'b0, lck};
  end

  pllseq_ctrl #(.LOCK_CYCLES(LOCK_CYCLES), .BYP_SETTLE(BYP_SETTLE)) u_ctrl (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_d(wr_data),
    .sel_we(sel_we), .byp_q(byp), .lck_q(lck)
  );

  pllseq_selreg u_sel (
    .clk(clk), .rst(rst), .we(sel_we), .d(sel_d), .q(sel_q)
  );

  pllseq_freq u_freq (
    .clk(clk), .rst(rst), .f(sel_q), .ref_sel(ref_sel),
    .freq_q(freq_hz), .ok_q(freq_ok)
  );

endmodule

// File: tb/sim_pll_mode_seq.sv
`timescale 1ns/1ps
module sim_pll_mode_seq;

  localparam int LOCKN = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  ref_sel = 2'd0;
  logic [8:0]  pll_status;
  logic [31:0] freq_hz;
  logic        freq_ok;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pll_mode_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ref_sel(ref_sel), .pll_status(pll_status), .freq_hz(freq_hz), .freq_ok(freq_ok)
  );

  // behavioural reference: phase 0 bypass, 1 entering bypass, 2 settling, 3 locked
  int      m_phase, m_left;
  bit      m_byp, m_lck, m_bsel, m_ok;
  int      m_mult, m_div;
  longint  m_freq;

  function automatic longint ref_of(input int s);
    case (s)
      0: return 64'd19200000;
      1: return 64'd24000000;
      2: return 64'd25000000;
      default: return 64'd26000000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_left = 0; m_byp = 1; m_lck = 0;
      m_mult = 0; m_div = 1; m_bsel = 0; m_freq = 0; m_ok = 1;
    end else begin
      longint p;
      bit took;
      p = longint'(m_mult) * (ref_of(int'(ref_sel)) / m_div);
      if (m_bsel || p >= 64'h1_0000_0000) begin m_ok = 0; m_freq = 0; end
      else begin m_ok = 1; m_freq = p; end
      took = 0;
      if (wr_en && !wr_sel) begin
        if (wr_data == 32'h4 && m_phase >= 2) begin
          m_phase = 1; m_left = 1; took = 1;
        end else if (wr_data == 32'h7 && m_phase <= 1) begin
          m_phase = 2; m_left = LOCKN - 1; m_byp = 0; m_lck = 0; took = 1;
        end
      end
      if (!took) begin
        if (m_phase == 1) begin
          if (m_left == 1) begin m_phase = 0; m_byp = 1; m_lck = 0; end
          else m_left--;
        end else if (m_phase == 2) begin
          if (wr_en && wr_sel) m_left = LOCKN - 1;
          else if (m_left == 1) begin m_phase = 3; m_lck = 1; end
          else m_left--;
        end
      end
      if (wr_en && wr_sel) begin
        m_mult = int'(wr_data[18:8]);
        m_div  = int'(wr_data[6:0]) + 1;
        m_bsel = wr_data[23];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (pll_status !== {m_byp, 7'b0, m_lck}) begin
        bad++;
        $display("FAIL R6/R12 model status: actual=%h expected=%h", pll_status, {m_byp, 7'b0, m_lck});
      end
      total++;
      if (freq_hz !== m_freq[31:0] || freq_ok !== m_ok) begin
        bad++;
        $display("FAIL R8 model freq: actual=%0d/%b expected=%0d/%b", freq_hz, freq_ok, m_freq, m_ok);
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] selw(input int mult, input int divm1, input bit bs);
    return (32'(mult) << 8) | 32'(divm1) | (32'(bs) << 23);
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 status", pll_status, 9'h100);
    chk("R1 freq", freq_hz, 0);
    chk("R1 ok", freq_ok, 1);

    // R7 junk bits at 31, 22:19 and 7 must not matter; R8 value
    wr(1, selw(10, 1, 0) | 32'h8078_0080);
    @(negedge clk);
    chk("R7 R8 freq 19.2M/2*10", freq_hz, 96000000);
    // R9 reference map
    ref_sel = 2'd1; @(negedge clk); chk("R9 ref1", freq_hz, 120000000);
    ref_sel = 2'd2; @(negedge clk); chk("R9 ref2", freq_hz, 125000000);
    ref_sel = 2'd3; @(negedge clk); chk("R9 ref3", freq_hz, 130000000);
    // R8 divide before multiply
    ref_sel = 2'd2;
    wr(1, selw(10, 2, 0)); @(negedge clk);
    chk("R8 truncating divide", freq_hz, 83333330);
    ref_sel = 2'd0;
    wr(1, selw(2047, 127, 0)); @(negedge clk);
    chk("R8 max divider", freq_hz, 307050000);
    // R10 bypass-clock select
    wr(1, selw(10, 1, 1)); @(negedge clk);
    chk("R10 ok", freq_ok, 0);
    chk("R10 freq", freq_hz, 0);
    // R11 overflow boundary
    ref_sel = 2'd3;
    wr(1, selw(165, 0, 0)); @(negedge clk);
    chk("R11 just fits", freq_hz, 64'd4290000000);
    chk("R11 just fits ok", freq_ok, 1);
    wr(1, selw(166, 0, 0)); @(negedge clk);
    chk("R11 overflow ok", freq_ok, 0);
    chk("R11 overflow freq", freq_hz, 0);

    // R5 0x4 while already in bypass
    wr(0, 32'h4);
    chk("R5 bypass repeat", pll_status, 9'h100);
    @(negedge clk);
    chk("R5 bypass repeat later", pll_status, 9'h100);

    // R3 lock timing
    wr(0, 32'h7);
    chk("R3 bypass cleared", pll_status, 9'h000);
    repeat (LOCKN - 2) @(negedge clk);
    chk("R3 not yet locked", pll_status, 9'h000);
    @(negedge clk);
    chk("R3 locked on time", pll_status, 9'h001);

    // R5 unknown value and lock repeat while locked
    wr(0, 32'h5);
    chk("R5 unknown mode", pll_status, 9'h001);
    wr(0, 32'h107);
    chk("R5 wide unknown mode", pll_status, 9'h001);
    wr(0, 32'h7);
    chk("R5 lock while locked", pll_status, 9'h001);

    // R2 bypass entry
    wr(0, 32'h4);
    chk("R2 one edge", pll_status, 9'h001);
    @(negedge clk);
    chk("R2 second edge", pll_status, 9'h100);

    // R4 select write restarts settle; R5 lock repeat during settle
    wr(0, 32'h7);
    repeat (4) @(negedge clk);
    wr(0, 32'h7);
    repeat (4) @(negedge clk);
    wr(1, selw(3, 0, 0));
    repeat (LOCKN - 2) @(negedge clk);
    chk("R4 still settling", pll_status, 9'h000);
    @(negedge clk);
    chk("R4 locked after restart", pll_status, 9'h001);

    // R12 bypass request then immediate lock request
    wr(0, 32'h4);
    wr(0, 32'h7);
    chk("R12 lock from entering", pll_status, 9'h000);
    repeat (LOCKN) @(negedge clk);
    chk("R12 relocked", pll_status, 9'h001);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule